// File: doc/BRIEF.md
# Angle-Windowed Event Timing Capture

This block times one digital command from a controller under test, such as an injector or ignition pulse, once per engine cycle. The window in which the command is watched is set by a minimum and a maximum cycle angle, and it may pass through zero. Each clock the block takes the current cycle angle, a free-running time count and the event line. It finds the active-going and inactive-going edges of the event line, applying a selectable polarity, and keeps the first complete event that falls in the window.

When the angle leaves the window, the block latches its results and pulses a one-cycle report strobe. The results are whether a full event was seen, the angles of its two edges and its length in time-base counts. Four error flags come with them: the line was active on every sample of the window, a start edge had no end, an end edge had no start, and the line stayed active longer than a programmable timeout. The per-window state then starts over for the next cycle. At a 40 MHz clock one time count is 25 ns.

Top module: `angle_event_capture`

## Requirements
- R1: While reset is asserted and after it is released, until the first report, the report strobe and every result and flag output is 0.
- R2: A sample is in the window when win_min <= angle <= win_max if win_min <= win_max, and when angle >= win_min or angle <= win_max otherwise. On the first clock edge whose sample is outside the window after an in-window sample, rpt_valid is 1 for the following cycle only, together with the latched results.
- R3: With active_high = 1 the event is active when evt_in = 1; with active_high = 0 it is active when evt_in = 0. All results refer to the active level.
- R4: If an active-going edge and a later inactive-going edge are both sampled inside the window, the report has evt_present = 1, start_angle equal to the angle sampled with the first active-going edge, and end_angle equal to the angle sampled with the inactive-going edge after it. This holds also when the window or the event passes through angle zero.
- R5: duration equals the time_now value at the end edge minus the value at the start edge, modulo 2^TIME_W. It is 0 when evt_present is 0.
- R6: err_orphan_start is 1 when an active-going edge was sampled in the window but no inactive-going edge followed it inside the window.
- R7: err_orphan_end is 1 when an inactive-going edge was sampled in the window with no active-going edge before it in that window.
- R8: err_all_active is 1 when the event was active on every in-window sample.
- R9: err_stuck is 1 when, since the previous report, there was a sample on which the event was active and had also been active on the previous sample, and on which time_now minus the time_now at the most recent active-going edge exceeded stuck_timeout.
- R10: Edges sampled outside the window have no effect on evt_present, the angles, duration or the orphan flags of the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| angle | input | ANG_W | Current cycle angle, unsigned |
| time_now | input | TIME_W | Free-running time count |
| evt_in | input | 1 | Digital event line from the unit under test |
| win_min | input | ANG_W | Window start angle |
| win_max | input | ANG_W | Window end angle (below win_min means the window passes zero) |
| active_high | input | 1 | 1: event active high, 0: active low |
| stuck_timeout | input | TIME_W | Longest allowed active time, in time counts |
| rpt_valid | output | 1 | One-cycle strobe, results valid |
| evt_present | output | 1 | Full start/end event seen in window |
| start_angle | output | ANG_W | Angle at the start edge |
| end_angle | output | ANG_W | Angle at the end edge |
| duration | output | TIME_W | Event length in time counts |
| err_stuck | output | 1 | Active longer than the timeout |
| err_all_active | output | 1 | Active on the whole window |
| err_orphan_start | output | 1 | Start edge without an end in window |
| err_orphan_end | output | 1 | End edge without a start in window |

## Verification
The angle steps once per clock around a 64-position cycle. Four windows are used: a plain one, two that pass through zero, and one that starts at zero. For each window, an event of five lengths is swept over ten start positions, with both polarities. The placements separate events fully inside the window from events that only start in it, only end in it, enclose it, cross zero, or stay outside it. Each of these leaves a distinct pattern of present and orphan flags. Event lengths 21 and 22 against a timeout of 20 fall on either side of the stuck-active threshold. The angle at which each report strobe arrives shows the window close and the one-cycle latency.

// File: rtl/aec_pkg.sv
package aec_pkg;

  // Window membership; a minimum above the maximum means the window spans zero.
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    if (lo <= hi) return (a >= lo) && (a <= hi);
    else          return (a >= lo) || (a <= hi);
  endfunction

endpackage

// File: rtl/aec_edge_detect.sv
module aec_edge_detect #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              active_high,
  input  logic [TIME_W-1:0] time_now,
  input  logic [TIME_W-1:0] stuck_timeout,
  output logic              act,
  output logic              rise,
  output logic              fall,
  output logic              stuck_now
);

  function automatic logic [TIME_W-1:0] elapsed(input logic [TIME_W-1:0] now,
                                                input logic [TIME_W-1:0] since);
    return now - since;
  endfunction

  logic              act_q;
  logic [TIME_W-1:0] act_t;

  assign act       = active_high ? evt_in : ~evt_in;
  assign rise      = act & ~act_q;
  assign fall      = ~act & act_q;
  assign stuck_now = act & act_q & (elapsed(time_now, act_t) > stuck_timeout);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      act_t <= '0;
    end else begin
      act_q <= act;
      if (rise) act_t <= time_now;
    end
  end

  // R9: a stuck detection needs the line active now and on the previous sample
  p_stuck_needs_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_now |-> (act && $past(act)));

endmodule

// File: rtl/aec_window_track.sv
module aec_window_track #(
  parameter int ANG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANG_W-1:0] angle,
  input  logic [ANG_W-1:0] win_min,
  input  logic [ANG_W-1:0] win_max,
  output logic             inw,
  output logic             win_open,
  output logic             win_close
);

  logic inw_q;

  assign inw       = aec_pkg::in_window(32'(angle), 32'(win_min), 32'(win_max));
  assign win_open  = inw & ~inw_q;
  assign win_close = ~inw & inw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) inw_q <= 1'b0;
    else        inw_q <= inw;
  end

endmodule

// File: rtl/aec_measure.sv
module aec_measure #(
  parameter int ANG_W  = 10,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ANG_W-1:0]  angle,
  input  logic [TIME_W-1:0] time_now,
  input  logic              act,
  input  logic              rise,
  input  logic              fall,
  input  logic              stuck_now,
  input  logic              inw,
  input  logic              win_open,
  input  logic              win_close,
  output logic              rpt_valid,
  output logic              evt_present,
  output logic [ANG_W-1:0]  start_angle,
  output logic [ANG_W-1:0]  end_angle,
  output logic [TIME_W-1:0] duration,
  output logic              err_stuck,
  output logic              err_all_active,
  output logic              err_orphan_start,
  output logic              err_orphan_end
);

  function automatic logic [TIME_W-1:0] span(input logic [TIME_W-1:0] t_end,
                                             input logic [TIME_W-1:0] t_beg);
    return t_end - t_beg;
  endfunction

  logic              got_s, got_e, orph_e, all_a, stuck_seen;
  logic [ANG_W-1:0]  s_ang, e_ang;
  logic [TIME_W-1:0] s_t, e_t;

  logic              n_s, n_e, n_oe, n_all;
  logic [ANG_W-1:0]  n_sang, n_eang;
  logic [TIME_W-1:0] n_st, n_et;

  // Per-sample update; the opening sample starts from a clean state.
  always_comb begin
    n_s    = win_open ? 1'b0 : got_s;
    n_e    = win_open ? 1'b0 : got_e;
    n_oe   = win_open ? 1'b0 : orph_e;
    n_all  = win_open ? 1'b1 : all_a;
    n_sang = s_ang;
    n_eang = e_ang;
    n_st   = s_t;
    n_et   = e_t;
    if (inw) begin
      if (rise && !n_s) begin
        n_s    = 1'b1;
        n_sang = angle;
        n_st   = time_now;
      end
      if (fall) begin
        if (n_s && !n_e) begin
          n_e    = 1'b1;
          n_eang = angle;
          n_et   = time_now;
        end else if (!n_s) begin
          n_oe = 1'b1;
        end
      end
      n_all = n_all & act;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_s <= 1'b0; got_e <= 1'b0; orph_e <= 1'b0; all_a <= 1'b0;
      stuck_seen <= 1'b0;
      s_ang <= '0; e_ang <= '0; s_t <= '0; e_t <= '0;
      rpt_valid <= 1'b0; evt_present <= 1'b0;
      start_angle <= '0; end_angle <= '0; duration <= '0;
      err_stuck <= 1'b0; err_all_active <= 1'b0;
      err_orphan_start <= 1'b0; err_orphan_end <= 1'b0;
    end else if (win_close) begin
      rpt_valid        <= 1'b1;
      evt_present      <= got_s & got_e;
      start_angle      <= s_ang;
      end_angle        <= e_ang;
      duration         <= (got_s & got_e) ? span(e_t, s_t) : '0;
      err_stuck        <= stuck_seen;
      err_all_active   <= all_a;
      err_orphan_start <= got_s & ~got_e;
      err_orphan_end   <= orph_e;
      stuck_seen       <= stuck_now;
      got_s <= 1'b0; got_e <= 1'b0; orph_e <= 1'b0; all_a <= 1'b0;
    end else begin
      rpt_valid  <= 1'b0;
      stuck_seen <= stuck_seen | stuck_now;
      got_s  <= n_s;    got_e  <= n_e;    orph_e <= n_oe;  all_a <= n_all;
      s_ang  <= n_sang; e_ang  <= n_eang; s_t    <= n_st;  e_t   <= n_et;
    end
  end

  // R6: a report never claims both a full event and an unfinished start
  p_present_excl_orphan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |-> !(evt_present && err_orphan_start));

  // R8: a window active throughout holds no end edge, so no full event
  p_all_active_no_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && err_all_active) |-> !evt_present);

  // R5: no event, no duration
  p_duration_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !evt_present) |-> (duration == '0));

endmodule

// File: rtl/angle_event_capture.sv
module angle_event_capture #(
  parameter int ANG_W  = 10,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ANG_W-1:0]  angle,
  input  logic [TIME_W-1:0] time_now,
  input  logic              evt_in,
  input  logic [ANG_W-1:0]  win_min,
  input  logic [ANG_W-1:0]  win_max,
  input  logic              active_high,
  input  logic [TIME_W-1:0] stuck_timeout,
  output logic              rpt_valid,
  output logic              evt_present,
  output logic [ANG_W-1:0]  start_angle,
  output logic [ANG_W-1:0]  end_angle,
  output logic [TIME_W-1:0] duration,
  output logic              err_stuck,
  output logic              err_all_active,
  output logic              err_orphan_start,
  output logic              err_orphan_end
);

  logic act, rise, fall, stuck_now;
  logic inw, win_open, win_close;

  aec_edge_detect #(.TIME_W(TIME_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .active_high(active_high),
    .time_now(time_now), .stuck_timeout(stuck_timeout),
    .act(act), .rise(rise), .fall(fall), .stuck_now(stuck_now)
  );

  aec_window_track #(.ANG_W(ANG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .angle(angle), .win_min(win_min), .win_max(win_max),
    .inw(inw), .win_open(win_open), .win_close(win_close)
  );

  aec_measure #(.ANG_W(ANG_W), .TIME_W(TIME_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .angle(angle), .time_now(time_now),
    .act(act), .rise(rise), .fall(fall), .stuck_now(stuck_now),
    .inw(inw), .win_open(win_open), .win_close(win_close),
    .rpt_valid(rpt_valid), .evt_present(evt_present),
    .start_angle(start_angle), .end_angle(end_angle), .duration(duration),
    .err_stuck(err_stuck), .err_all_active(err_all_active),
    .err_orphan_start(err_orphan_start), .err_orphan_end(err_orphan_end)
  );

  // R2: a window close yields a report strobe on the next cycle
  p_close_reports_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> rpt_valid);

  // R2: the report strobe lasts one cycle
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid |=> !rpt_valid);

  // R10: a report only follows a sample that was in the window
  p_report_needs_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpt_valid) |-> $past(inw, 2));

endmodule

// File: tb/angle_event_capture_test.sv
`timescale 1ns/1ps
module angle_event_capture_test;

  localparam int AW = 6;
  localparam int TW = 16;
  localparam int NA = 64;
  localparam int TMO = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] angle = '0;
  logic [TW-1:0] time_now = '0;
  logic          evt_in = 1'b0;
  logic [AW-1:0] win_min = '0;
  logic [AW-1:0] win_max = '0;
  logic          active_high = 1'b1;
  logic [TW-1:0] stuck_timeout = TW'(TMO);
  logic          rpt_valid, evt_present, err_stuck, err_all_active;
  logic          err_orphan_start, err_orphan_end;
  logic [AW-1:0] start_angle, end_angle;
  logic [TW-1:0] duration;

  angle_event_capture #(.ANG_W(AW), .TIME_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .angle(angle), .time_now(time_now), .evt_in(evt_in),
    .win_min(win_min), .win_max(win_max), .active_high(active_high),
    .stuck_timeout(stuck_timeout), .rpt_valid(rpt_valid), .evt_present(evt_present),
    .start_angle(start_angle), .end_angle(end_angle), .duration(duration),
    .err_stuck(err_stuck), .err_all_active(err_all_active),
    .err_orphan_start(err_orphan_start), .err_orphan_end(err_orphan_end)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int actr = 0;
  int tctr = 0;

  // captured last report of a pattern
  int c_cnt, c_ang, c_sa, c_ea, c_dur;
  bit c_pres, c_st, c_all, c_os, c_oe;

  task automatic chk(input string tag, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic run_pattern(input int mn, input int mx, input int a,
                             input int len, input bit pol);
    int last_ang;
    int rel_s, rel_e, wl, d0, b;
    bit e_s, e_e, e_pres, e_os, e_oe, e_all, e_st;
    string tg;
    last_ang = -1;
    c_cnt = 0;
    for (int k = 0; k < 3 * NA + 8; k++) begin
      @(negedge clk);
      if (rpt_valid) begin
        c_cnt++;
        c_ang = last_ang; c_pres = evt_present; c_sa = int'(start_angle);
        c_ea = int'(end_angle); c_dur = int'(duration); c_st = err_stuck;
        c_all = err_all_active; c_os = err_orphan_start; c_oe = err_orphan_end;
      end
      win_min = AW'(mn); win_max = AW'(mx); active_high = pol;
      angle = AW'(actr);
      time_now = TW'(tctr);
      evt_in = ((((actr - a) % NA + NA) % NA) < len) ? pol : ~pol;
      last_ang = actr;
      actr = (actr + 1) % NA;
      tctr++;
    end
    // expected, by positions relative to the window start
    wl    = ((mx - mn) % NA + NA) % NA + 1;
    b     = (a + len) % NA;
    rel_s = ((a - mn) % NA + NA) % NA;
    rel_e = ((b - mn) % NA + NA) % NA;
    d0    = ((mn - a) % NA + NA) % NA;
    e_s    = rel_s < wl;
    e_e    = rel_e < wl;
    e_pres = e_s && e_e && (rel_e > rel_s);
    e_os   = e_s && !e_pres;
    e_oe   = e_e && !(e_s && rel_s < rel_e);
    e_all  = (d0 + wl - 1) < len;
    e_st   = (len - 1) > TMO;
    tg = pol ? "" : " R3";
    chk({"R2 report count", tg}, int'(c_cnt >= 2), 1);
    chk({"R2 report angle", tg}, c_ang, (mx + 1) % NA);
    chk({"R4 present", tg}, int'(c_pres), int'(e_pres));
    chk({"R6 orphan start", tg}, int'(c_os), int'(e_os));
    chk({"R7 orphan end", tg}, int'(c_oe), int'(e_oe));
    chk({"R8 all active", tg}, int'(c_all), int'(e_all));
    chk({"R9 stuck", tg}, int'(c_st), int'(e_st));
    if (e_pres) begin
      chk({"R4 start angle", tg}, c_sa, a);
      chk({"R4 end angle", tg}, c_ea, b);
      chk({"R5 duration", tg}, c_dur, len);
    end else begin
      chk({"R5 duration zero", tg}, c_dur, 0);
    end
    if (!e_s && !e_e)
      chk({"R10 outside edges", tg}, int'(c_pres) + int'(c_os) + int'(c_oe), 0);
  endtask

  int wmin [4] = '{10, 50, 60, 0};
  int wmax [4] = '{40, 5, 2, 30};
  int lens [5] = '{1, 5, 21, 22, 45};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 strobe", int'(rpt_valid), 0);
    chk("R1 results", int'(evt_present) + int'(start_angle) + int'(end_angle) + int'(duration), 0);
    chk("R1 flags", int'(err_stuck) + int'(err_all_active) + int'(err_orphan_start) + int'(err_orphan_end), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(rpt_valid) + int'(evt_present), 0);
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 10; s++)
        for (int l = 0; l < 5; l++)
          run_pattern(wmin[w], wmax[w], (s * 7) % NA, lens[l], ((s + l) % 2) == 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule